// File: doc/BRIEF.md
# Frame Transmit Buffer with Start Threshold

This block sits between a word-wide producer and a byte-wide MAC transmit engine. It stores up to 256 bytes as 64 entries of 32 bits each. The producer pushes words that carry an end-of-frame marker. On the closing word of a frame, a 2-bit field gives how many of its bytes are valid. On the other side, a byte stream with a valid/ready handshake feeds the transmit engine. Each word is unpacked least-significant byte first, and a last flag marks the final byte of every frame.

The frame at the head of the buffer is held back until one of two things happens: enough of it has been buffered to reach a programmable byte threshold, or its end-of-frame word has arrived. This keeps the transmit engine from starting a frame that it could not sustain, while short frames still go out. Once a frame is released, it drains to its end without being gated again. The threshold is tested again only at the start of the next frame.

Two status flags compare the entry count against programmable levels. One rises when the buffer is above a high-water mark. The other rises when the buffer is below a low-water mark.

Top module: `frame_tx_buffer`

## Requirements
- R1: After reset the buffer is empty. `wrReady` is 1, `txValid` is 0, `partFull` is 0, and `partEmpty` is 1 whenever `peThresh` is above zero. A reset applied mid-frame discards everything that was stored.
- R2: The buffer holds 64 words. When 64 words are stored, `wrReady` is 0. A word offered in that state is not stored and never appears at the output.
- R3: The bytes of each word leave in order: bits 7:0 first, then 15:8, then 23:16, then 31:24.
- R4: On a word marked last, `wrBytes` gives the number of valid bytes: 0 means 4, and 1 to 3 mean that many bytes, starting with the low bytes. `txLast` is 1 only with the final valid byte of a frame, and no byte follows it for that frame.
- R5: A frame at the head whose end-of-frame word is not yet stored does not start while 4 × (stored words) < `startThresh`. It starts within three cycles of the stored amount reaching the threshold.
- R6: A frame whose end-of-frame word has been stored is sent even if it is shorter than `startThresh`.
- R7: Once a frame has started, the rest of it is sent as its words arrive, even if the stored amount falls below `startThresh`.
- R8: `partFull` is 1 exactly when the number of stored words is greater than `pfThresh`.
- R9: `partEmpty` is 1 exactly when the number of stored words is less than `peThresh`.
- R10: While `txValid` is 1 and `txReady` is 0, `txValid` stays 1 and `txData` stays unchanged.
- R11: Frames written back to back leave as separate frames, in order. Each has its own `txLast`, and no byte is lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | Producer offers a word |
| wrReady | output | 1 | Buffer can take a word |
| wrData | input | 32 | Word; bits 7:0 are sent first |
| wrLast | input | 1 | Word closes its frame |
| wrBytes | input | 2 | Valid bytes in a closing word (0 = 4) |
| startThresh | input | 9 | Bytes of the head frame required before it starts |
| pfThresh | input | 7 | High-water mark in words |
| peThresh | input | 7 | Low-water mark in words |
| txValid | output | 1 | Byte available |
| txReady | input | 1 | Transmit engine takes the byte |
| txData | output | 8 | Byte |
| txLast | output | 1 | Final byte of the frame |
| partFull | output | 1 | Stored words above `pfThresh` |
| partEmpty | output | 1 | Stored words below `peThresh` |

## Verification
The start gate is exercised with several input patterns, and each one separates a different cause of release:
- A frame shorter than the threshold shows release on end-of-frame.
- A long frame written slowly against a 32-byte threshold shows release on the byte count. Because the frame then runs dry and later resumes with one word, it also shows that a started frame is not gated again.
- Back-to-back frames, written while the output is stalled, show that frame boundaries and last flags stay separate.
- A throttled reader shows that bytes are held during stalls.

A fill to 64 words, with the threshold placed at full size, steps both flags through every count and shows that a word offered while full is dropped.

// File: rtl/ftb_pkg.sv
package ftb_pkg;
  // strobes from control to storage
  typedef struct packed {
    logic push;   // store the offered word
    logic pop;    // move head word into the unpack register
  } ftbStrobe_t;
endpackage

// File: rtl/ftb_store.sv
module ftb_store
  import ftb_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ftbStrobe_t                 strobe,
  input  logic [DATA_W-1:0]          wrData,
  input  logic                       wrLast,
  input  logic [$clog2(DATA_W/8)-1:0] wrBytes,
  input  logic [$clog2(DATA_W/8)-1:0] byteIdx,
  output logic [$clog2(DEPTH):0]     count,
  output logic [$clog2(DEPTH):0]     eofCount,
  output logic                       holdLast,
  output logic [$clog2(DATA_W/8)-1:0] holdBytes,
  output logic [7:0]                 txData
);
  localparam int BYTES  = DATA_W / 8;
  localparam int BIDX_W = $clog2(BYTES);
  localparam int PTR_W  = $clog2(DEPTH);
  localparam int CNT_W  = PTR_W + 1;
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [DATA_W-1:0] memData  [DEPTH];
  logic              memLast  [DEPTH];
  logic [BIDX_W-1:0] memBytes [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [DATA_W-1:0] holdWord;
  logic              eofIn, eofOut;

  assign eofIn  = strobe.push && wrLast;
  assign eofOut = strobe.pop && memLast[rdPtr];

  always_ff @(posedge clk) begin
    if (strobe.push) begin
      memData[wrPtr]  <= wrData;
      memLast[wrPtr]  <= wrLast;
      memBytes[wrPtr] <= wrBytes;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      count     <= '0;
      eofCount  <= '0;
      holdWord  <= '0;
      holdLast  <= 1'b0;
      holdBytes <= '0;
    end else begin
      if (strobe.push) wrPtr <= wrPtr + 1'b1;
      if (strobe.pop) begin
        rdPtr     <= rdPtr + 1'b1;
        holdWord  <= memData[rdPtr];
        holdLast  <= memLast[rdPtr];
        holdBytes <= memBytes[rdPtr];
      end
      case ({strobe.push, strobe.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      case ({eofIn, eofOut})
        2'b10:   eofCount <= eofCount + 1'b1;
        2'b01:   eofCount <= eofCount - 1'b1;
        default: eofCount <= eofCount;
      endcase
    end
  end

  assign txData = holdWord[byteIdx*8 +: 8];

  AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (!rstN)
    strobe.push |-> count < FULL); // R2
  AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pop |-> count != '0); // R2
  AST_EOF_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    eofCount <= count); // R6
endmodule

// File: rtl/ftb_ctrl.sv
module ftb_ctrl
  import ftb_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 32
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               wrValid,
  input  logic [$clog2(DEPTH)+$clog2(DATA_W/8):0] startThresh,
  input  logic [$clog2(DEPTH):0]             pfThresh,
  input  logic [$clog2(DEPTH):0]             peThresh,
  input  logic [$clog2(DEPTH):0]             count,
  input  logic [$clog2(DEPTH):0]             eofCount,
  input  logic                               holdLast,
  input  logic [$clog2(DATA_W/8)-1:0]        holdBytes,
  input  logic                               txReady,
  output logic                               wrReady,
  output logic                               txValid,
  output logic                               txLast,
  output logic                               partFull,
  output logic                               partEmpty,
  output logic [$clog2(DATA_W/8)-1:0]        byteIdx,
  output ftbStrobe_t                         strobe
);
  localparam int BYTES  = DATA_W / 8;
  localparam int BIDX_W = $clog2(BYTES);
  localparam int CNT_W  = $clog2(DEPTH) + 1;
  localparam int TH_W   = CNT_W + BIDX_W;
  localparam logic [CNT_W-1:0]  FULL    = CNT_W'(DEPTH);
  localparam logic [BIDX_W-1:0] TOP_IDX = BIDX_W'(BYTES - 1);

  logic              holdValid, released;
  logic [TH_W-1:0]   bufBytes;
  logic              startOk, take, wordEnd;
  logic [BIDX_W-1:0] lastIdx;

  assign bufBytes = {count, {BIDX_W{1'b0}}};
  assign startOk  = (eofCount != '0) || (bufBytes >= startThresh);
  assign wrReady  = (count != FULL);

  assign strobe.push = wrValid && wrReady;
  assign strobe.pop  = !holdValid && (count != '0) && (released || startOk);

  assign lastIdx = (holdLast && holdBytes != '0) ? holdBytes - 1'b1 : TOP_IDX;
  assign wordEnd = (byteIdx == lastIdx);
  assign txValid = holdValid;
  assign txLast  = holdValid && holdLast && wordEnd;
  assign take    = holdValid && txReady;

  assign partFull  = count > pfThresh;
  assign partEmpty = count < peThresh;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdValid <= 1'b0;
      released  <= 1'b0;
      byteIdx   <= '0;
    end else begin
      if (strobe.pop) begin
        holdValid <= 1'b1;
        released  <= 1'b1;
        byteIdx   <= '0;
      end else if (take) begin
        if (wordEnd) begin
          holdValid <= 1'b0;
          if (holdLast) released <= 1'b0;
        end else begin
          byteIdx <= byteIdx + 1'b1;
        end
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL); // R2
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady) |=> (txValid && $stable(byteIdx))); // R10
  AST_GATE_CLOSED: assert property (@(posedge clk) disable iff (!rstN)
    (!released && eofCount == '0 && bufBytes < startThresh) |=> !txValid); // R5
  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    (txLast && txReady) |=> !txValid); // R4
endmodule

// File: rtl/frame_tx_buffer.sv
module frame_tx_buffer
  import ftb_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrValid,
  output logic        wrReady,
  input  logic [31:0] wrData,
  input  logic        wrLast,
  input  logic [1:0]  wrBytes,
  input  logic [8:0]  startThresh,
  input  logic [6:0]  pfThresh,
  input  logic [6:0]  peThresh,
  output logic        txValid,
  input  logic        txReady,
  output logic [7:0]  txData,
  output logic        txLast,
  output logic        partFull,
  output logic        partEmpty
);
  localparam int BIDX_W = $clog2(DATA_W / 8);
  localparam int CNT_W  = $clog2(DEPTH) + 1;

  ftbStrobe_t        strobe;
  logic [CNT_W-1:0]  count, eofCount;
  logic              holdLast;
  logic [BIDX_W-1:0] holdBytes, byteIdx;

  ftb_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .wrData(wrData), .wrLast(wrLast), .wrBytes(wrBytes),
    .byteIdx(byteIdx), .count(count), .eofCount(eofCount),
    .holdLast(holdLast), .holdBytes(holdBytes), .txData(txData)
  );

  ftb_ctrl #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrValid(wrValid),
    .startThresh(startThresh), .pfThresh(pfThresh), .peThresh(peThresh),
    .count(count), .eofCount(eofCount),
    .holdLast(holdLast), .holdBytes(holdBytes), .txReady(txReady),
    .wrReady(wrReady), .txValid(txValid), .txLast(txLast),
    .partFull(partFull), .partEmpty(partEmpty),
    .byteIdx(byteIdx), .strobe(strobe)
  );
endmodule

// File: tb/frame_tx_buffer_bench.sv
module frame_tx_buffer_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN, wrValid, wrReady, wrLast, txValid, txReady, txLast, partFull, partEmpty;
  logic [31:0] wrData;
  logic [1:0]  wrBytes;
  logic [8:0]  startThresh;
  logic [6:0]  pfThresh, peThresh;
  logic [7:0]  txData;

  frame_tx_buffer u_frame_tx_buffer (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrReady(wrReady),
    .wrData(wrData), .wrLast(wrLast), .wrBytes(wrBytes),
    .startThresh(startThresh), .pfThresh(pfThresh), .peThresh(peThresh),
    .txValid(txValid), .txReady(txReady), .txData(txData), .txLast(txLast),
    .partFull(partFull), .partEmpty(partEmpty)
  );

  int checks = 0;
  int errors = 0;
  logic [7:0] got [0:511];
  logic       gotLast [0:511];
  int gotN;

  // stimulus / expected-result vectors: words, closing byte count, threshold, gap, throttle, bytes out
  localparam int NV = 4;
  localparam int V_WORDS [NV] = '{2, 12, 3, 5};
  localparam int V_LASTB [NV] = '{1, 0, 2, 3};
  localparam int V_THR   [NV] = '{32, 32, 8, 16};
  localparam int V_GAP   [NV] = '{0, 6, 0, 0};
  localparam int V_THROT [NV] = '{0, 0, 0, 1};
  localparam int V_NOUT  [NV] = '{5, 48, 10, 19};

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] expByte(input int seed, input int k);
    return 8'(seed * 37 + k);
  endfunction

  task automatic pushWord(input logic [31:0] d, input logic l, input logic [1:0] b);
    @(negedge clk);
    wrValid = 1'b1; wrData = d; wrLast = l; wrBytes = b;
    while (!wrReady) @(negedge clk);
    @(posedge clk); #1;
    wrValid = 1'b0; wrLast = 1'b0;
  endtask

  task automatic writeFrame(input int seed, input int nWords, input int lastB, input int gap, input int base);
    for (int w = 0; w < nWords; w++) begin
      logic [31:0] d;
      bit isLast;
      isLast = (w == nWords - 1);
      for (int j = 0; j < 4; j++) begin
        if (isLast && lastB != 0 && j >= lastB) d[j*8 +: 8] = 8'hEE;
        else d[j*8 +: 8] = expByte(seed, base + w*4 + j);
      end
      pushWord(d, isLast, 2'(lastB));
      repeat (gap) @(posedge clk);
    end
  endtask

  task automatic readBytes(input int n, input bit throttle);
    int k = 0;
    int cyc = 0;
    logic [7:0] held = 8'h00;
    bit pend = 1'b0;
    while (k < n) begin
      @(negedge clk);
      if (pend) begin
        check(txValid && txData == held, "R10", "stalled byte", txData, held);
        pend = 1'b0;
      end
      txReady = throttle ? (cyc % 3 != 2) : 1'b1;
      cyc++;
      if (txValid && txReady) begin
        got[gotN] = txData; gotLast[gotN] = txLast; gotN++; k++;
      end else if (txValid) begin
        held = txData; pend = 1'b1;
      end
    end
    @(posedge clk); #1;
    txReady = 1'b0;
  endtask

  task automatic checkFrame(input int start, input int seed, input int nBytes, input string req);
    for (int k = 0; k < nBytes; k++) begin
      check(got[start+k] == expByte(seed, k), "R3", {req, " byte"}, got[start+k], expByte(seed, k));
      check(gotLast[start+k] == (k == nBytes - 1), "R4", {req, " last flag"}, gotLast[start+k], k == nBytes - 1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; wrValid = 1'b0; wrData = '0; wrLast = 1'b0; wrBytes = '0;
    txReady = 1'b0; startThresh = 9'd256; pfThresh = 7'd3; peThresh = 7'd2;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(wrReady == 1'b1, "R1", "wrReady", wrReady, 1);
    check(txValid == 1'b0, "R1", "txValid", txValid, 0);
    check(partFull == 1'b0, "R1", "partFull", partFull, 0);
    check(partEmpty == 1'b1, "R1", "partEmpty", partEmpty, 1);

    // R8 R9 R2: fill to 64 words with the threshold at full size
    for (int i = 1; i <= 64; i++) begin
      logic [31:0] d;
      for (int j = 0; j < 4; j++) d[j*8 +: 8] = expByte(9, (i-1)*4 + j);
      pushWord(d, 1'b0, 2'd0);
      check(partFull == (i > 3), "R8", "partFull vs count", partFull, i > 3);
      check(partEmpty == (i < 2), "R9", "partEmpty vs count", partEmpty, i < 2);
    end
    @(negedge clk);
    check(wrReady == 1'b0, "R2", "wrReady at 64 words", wrReady, 0);
    wrValid = 1'b1; wrData = 32'hDEADBEEF; wrLast = 1'b1; wrBytes = 2'd0;
    @(posedge clk); #1;
    wrValid = 1'b0; wrLast = 1'b0;
    gotN = 0;
    readBytes(256, 1'b0);
    writeFrame(9, 1, 0, 0, 256);
    readBytes(4, 1'b0);
    checkFrame(0, 9, 260, "R2 full fill");
    repeat (3) @(negedge clk);
    check(txValid == 1'b0, "R2", "no dropped word sent", txValid, 0);
    check(partEmpty == 1'b1, "R9", "partEmpty when drained", partEmpty, 1);

    // R5 R7: threshold gating with slow arrival
    startThresh = 9'd32;
    for (int w = 0; w < 7; w++) begin
      logic [31:0] d;
      for (int j = 0; j < 4; j++) d[j*8 +: 8] = expByte(5, w*4 + j);
      pushWord(d, 1'b0, 2'd0);
    end
    repeat (10) @(negedge clk);
    check(txValid == 1'b0, "R5", "held below threshold", txValid, 0);
    begin
      logic [31:0] d;
      for (int j = 0; j < 4; j++) d[j*8 +: 8] = expByte(5, 28 + j);
      pushWord(d, 1'b0, 2'd0);
    end
    repeat (3) @(negedge clk);
    check(txValid == 1'b1, "R5", "starts at threshold", txValid, 1);
    gotN = 0;
    readBytes(32, 1'b0);
    repeat (5) @(negedge clk);
    check(txValid == 1'b0, "R7", "run dry mid-frame", txValid, 0);
    writeFrame(5, 1, 0, 0, 32);
    readBytes(4, 1'b0);
    checkFrame(0, 5, 36, "R7 resumed frame");

    // table of frames: R6 short, R5 long slow, R10 throttled
    for (int i = 0; i < NV; i++) begin
      startThresh = 9'(V_THR[i]);
      gotN = 0;
      fork
        writeFrame(i + 1, V_WORDS[i], V_LASTB[i], V_GAP[i], 0);
        readBytes(V_NOUT[i], V_THROT[i] != 0);
      join
      checkFrame(0, i + 1, V_NOUT[i], i == 0 ? "R6 short frame" : "R5 table frame");
      repeat (3) @(negedge clk);
      check(txValid == 1'b0, "R4", "no byte after last", txValid, 0);
    end

    // R11 back-to-back frames, second released by its end marker
    startThresh = 9'd64;
    gotN = 0;
    writeFrame(11, 3, 0, 0, 0);
    writeFrame(12, 2, 2, 0, 0);
    readBytes(18, 1'b0);
    checkFrame(0, 11, 12, "R11 first frame");
    checkFrame(12, 12, 6, "R11 second frame");

    // R1 reset mid-frame discards contents
    startThresh = 9'd256; peThresh = 7'd1;
    writeFrame(13, 3, 0, 0, 0);
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(txValid == 1'b0, "R1", "txValid after reset", txValid, 0);
    check(partEmpty == 1'b1, "R1", "empty after reset", partEmpty, 1);
    check(wrReady == 1'b1, "R1", "wrReady after reset", wrReady, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule